// File: doc/BRIEF.md
# Pipelined ADC Digital Code Corrector

This block turns the raw per-stage codes of a pipelined analog-to-digital converter into one corrected binary output word. Every stage before the last resolves one step more than it keeps. Its code therefore overlaps the next stage's code by one bit. Codes are merged by shifted addition rather than by concatenation. This lets a later stage absorb a one-step decision error made by an earlier comparator.

The stages work one after another on the same sample, so a sample's code from stage i arrives i cycles after its stage 0 code. Each non-final code passes through a delay line whose depth is the number of stages that follow it. All codes of one sample therefore meet at the adder in the same cycle. The sum is then registered together with an output strobe. The stage count, the non-final code width and the final code width are parameters. With the defaults there are eight stages with three-level codes, and they form a 9-bit word. Four stages of 4, 4, 4 and 3 bits give a 12-bit word.

Top module: `pipe_adc_corrector`

## Requirements
- R1: The output word is the sum of the final code and every non-final code, all for the same sample. Non-final stage i, counted from 0 at the front, is shifted left by (NUM_STAGES-2-i)*(CODE_W-1)+LAST_W-1 bits. The final code is added unshifted. The word is NUM_STAGES-1 times (CODE_W-1) plus LAST_W bits wide.
- R2: Each stage can be modelled as an ideal quantizer. A non-final stage's code c counts how many of its thresholds the stage input reaches, at (t+0.5)/2^CODE_W of full scale for t = 1 .. 2^CODE_W-2. It passes on the residue 2^(CODE_W-1)*(input - c/2^CODE_W). The final stage takes the floor of input*2^LAST_W. Under this model, the word equals floor(x*2^OUT_W) for an analog fraction x.
- R3: A non-final code may be off by one step, up or down. If the later stages quantize the residue that the wrong code leaves, and that residue stays inside full scale, the word is the same as in the ideal case.
- R4: A sample's stage-i code and strobe are presented i cycles after its stage-0 code. The word and out_vld_o appear NUM_STAGES cycles after the stage-0 code, one cycle after the final code.
- R5: If any stage strobe of a sample is low, no output strobe is produced in that sample's output cycle.
- R6: While out_vld_o is low, out_word_o keeps the last word it delivered.
- R7: A non-final code above 2^CODE_W-2 is used as 2^CODE_W-2. For example, 3 is treated as 2 when CODE_W=2.
- R8: The low LAST_W-1 bits of the word are equal to the low LAST_W-1 bits of the final code.
- R9: While rst_n is low, and until the first complete sample arrives, out_vld_o is 0 and out_word_o is 0.
- R10: A new sample may start in every cycle. Outputs come out one per cycle, in the order the samples started.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| stage_code_i | input | (NUM_STAGES-1)*CODE_W | Codes of the non-final stages; stage i occupies bits [i*CODE_W +: CODE_W], stage 0 at the bottom |
| last_code_i | input | LAST_W | Code of the final stage |
| stage_vld_i | input | NUM_STAGES | Per-stage strobe; bit i for stage i, bit NUM_STAGES-1 for the final stage |
| out_vld_o | output | 1 | Corrected word valid |
| out_word_o | output | (NUM_STAGES-1)*(CODE_W-1)+LAST_W | Corrected word |

## Verification
The bench is built with the default eight stages, 2-bit non-final codes and a 2-bit final code. With these values every non-final code takes all three legal levels, and the unused value 3 can be driven to test clamping. The 9-bit word is also small enough that a one-hot sweep reaches every shift weight. The bench parameters pass straight through to the block. Overriding them to four stages of 4, 4 and 3 bits brings the 12-bit, 15-level configuration under the same analog model and the same perturbation checks.

// File: rtl/adc_corr_pkg.sv
package adc_corr_pkg;

    // Width of the corrected word for a given stage layout.
    function automatic int out_width(input int n_stages, input int code_w, input int last_w);
        return (n_stages - 1) * (code_w - 1) + last_w;
    endfunction

    // Left shift applied to the code of non-final stage idx (0 = front).
    function automatic int stage_shift(input int idx, input int n_stages,
                                       input int code_w, input int last_w);
        return (n_stages - 2 - idx) * (code_w - 1) + last_w - 1;
    endfunction

endpackage

// File: rtl/corr_code_limit.sv
module corr_code_limit #(
    parameter int CODE_W = 2
) (
    input  logic [CODE_W-1:0] code_i,
    output logic [CODE_W-1:0] code_o
);
    // Highest legal level of a redundant stage: all ones except the LSB.
    localparam logic [CODE_W-1:0] CODE_MAX = {{(CODE_W-1){1'b1}}, 1'b0};

    always_comb begin
        code_o = (code_i > CODE_MAX) ? CODE_MAX : code_i;
    end
endmodule

// File: rtl/corr_delay_line.sv
module corr_delay_line #(
    parameter int W     = 2,
    parameter int DEPTH = 1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         in_vld_i,
    input  logic [W-1:0] in_code_i,
    output logic         out_vld_o,
    output logic [W-1:0] out_code_o
);
    generate
        if (DEPTH == 0) begin : g_pass
            assign out_vld_o  = in_vld_i;
            assign out_code_o = in_code_i;
        end else begin : g_pipe
            typedef struct packed {
                logic         vld;
                logic [W-1:0] code;
            } slot_t;

            slot_t [DEPTH-1:0] slot_d;
            slot_t [DEPTH-1:0] slot_q;

            always_comb begin
                slot_d[0].vld  = in_vld_i;
                slot_d[0].code = in_code_i;
                for (int k = 1; k < DEPTH; k++) begin
                    slot_d[k] = slot_q[k-1];
                end
            end

            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    slot_q <= '0;
                end else begin
                    slot_q <= slot_d;
                end
            end

            assign out_vld_o  = slot_q[DEPTH-1].vld;
            assign out_code_o = slot_q[DEPTH-1].code;
        end
    endgenerate
endmodule

// File: rtl/corr_overlap_sum.sv
module corr_overlap_sum
    import adc_corr_pkg::*;
#(
    parameter int NUM_STAGES = 8,
    parameter int CODE_W     = 2,
    parameter int LAST_W     = 2,
    parameter int OUT_W      = 9
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic [(NUM_STAGES-1)*CODE_W-1:0] algn_code_i,
    input  logic [LAST_W-1:0]                last_code_i,
    output logic [OUT_W-1:0]                 sum_o
);
    localparam int NF = NUM_STAGES - 1;
    localparam logic [CODE_W-1:0] CODE_MAX = {{(CODE_W-1){1'b1}}, 1'b0};

    logic [OUT_W-1:0] acc [NUM_STAGES];

    assign acc[0] = OUT_W'(last_code_i);

    generate
        for (genvar i = 0; i < NF; i++) begin : g_term
            localparam int SH = stage_shift(i, NUM_STAGES, CODE_W, LAST_W);
            logic [CODE_W-1:0] code_w;
            assign code_w   = algn_code_i[i*CODE_W +: CODE_W];
            assign acc[i+1] = acc[i] + (OUT_W'(code_w) << SH);

            // Codes reaching the adder were limited upstream in the delay path.
            AST_CODE_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
                code_w <= CODE_MAX); // R7
        end
    endgenerate

    assign sum_o = acc[NF];
endmodule

// File: rtl/pipe_adc_corrector.sv
module pipe_adc_corrector
    import adc_corr_pkg::*;
#(
    parameter int NUM_STAGES = 8,
    parameter int CODE_W     = 2,
    parameter int LAST_W     = 2
) (
    input  logic                                         clk,
    input  logic                                         rst_n,
    input  logic [(NUM_STAGES-1)*CODE_W-1:0]             stage_code_i,
    input  logic [LAST_W-1:0]                            last_code_i,
    input  logic [NUM_STAGES-1:0]                        stage_vld_i,
    output logic                                         out_vld_o,
    output logic [(NUM_STAGES-1)*(CODE_W-1)+LAST_W-1:0]  out_word_o
);
    localparam int OUT_W = out_width(NUM_STAGES, CODE_W, LAST_W);
    localparam int NF    = NUM_STAGES - 1;

    logic [CODE_W-1:0]    lim_code [NF];
    logic [NF*CODE_W-1:0] algn_code;
    logic [NUM_STAGES-1:0] algn_vld;
    logic                 all_algn;
    logic [OUT_W-1:0]     sum_w;

    // Each redundant stage: limit, then delay by the number of later stages.
    generate
        for (genvar i = 0; i < NF; i++) begin : g_stage
            corr_code_limit #(.CODE_W(CODE_W)) u_lim (
                .code_i (stage_code_i[i*CODE_W +: CODE_W]),
                .code_o (lim_code[i])
            );
            corr_delay_line #(.W(CODE_W), .DEPTH(NUM_STAGES - 1 - i)) u_dly (
                .clk        (clk),
                .rst_n      (rst_n),
                .in_vld_i   (stage_vld_i[i]),
                .in_code_i  (lim_code[i]),
                .out_vld_o  (algn_vld[i]),
                .out_code_o (algn_code[i*CODE_W +: CODE_W])
            );
        end
    endgenerate

    // The final stage arrives last and feeds the adder directly.
    assign algn_vld[NF] = stage_vld_i[NF];
    assign all_algn     = &algn_vld;

    corr_overlap_sum #(
        .NUM_STAGES (NUM_STAGES),
        .CODE_W     (CODE_W),
        .LAST_W     (LAST_W),
        .OUT_W      (OUT_W)
    ) u_sum (
        .clk         (clk),
        .rst_n       (rst_n),
        .algn_code_i (algn_code),
        .last_code_i (last_code_i),
        .sum_o       (sum_w)
    );

    typedef struct packed {
        logic             vld;
        logic [OUT_W-1:0] word;
    } out_state_t;

    out_state_t st_d;
    out_state_t st_q;

    always_comb begin
        st_d     = st_q;
        st_d.vld = all_algn;
        if (all_algn) begin
            st_d.word = sum_w;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign out_vld_o  = st_q.vld;
    assign out_word_o = st_q.word;

    AST_VLD_AFTER_LAST: assert property (@(posedge clk) disable iff (!rst_n)
        out_vld_o |-> $past(stage_vld_i[NF])); // R4

    AST_HOLD_WORD: assert property (@(posedge clk) disable iff (!rst_n)
        !all_algn |=> $stable(out_word_o)); // R6

    generate
        if (LAST_W >= 2) begin : g_lsb_chk
            AST_LSB_PASSTHRU: assert property (@(posedge clk) disable iff (!rst_n)
                out_vld_o |-> out_word_o[LAST_W-2:0] == $past(last_code_i[LAST_W-2:0])); // R8
        end
    endgenerate
endmodule

// File: tb/pipe_adc_corrector_test.sv
`timescale 1ns/1ps
module pipe_adc_corrector_test #(
    parameter int NS = 8,
    parameter int CW = 2,
    parameter int LW = 2
);
    localparam int OW = (NS - 1) * (CW - 1) + LW;
    localparam longint VREF = 64'sh1_0000_0000;
    localparam int CMAX = (1 << CW) - 2;

    logic                 clk = 1'b0;
    logic                 rst_n = 1'b0;
    logic [(NS-1)*CW-1:0] stage_code_i = '0;
    logic [LW-1:0]        last_code_i = '0;
    logic [NS-1:0]        stage_vld_i = '0;
    logic                 out_vld_o;
    logic [OW-1:0]        out_word_o;

    pipe_adc_corrector #(.NUM_STAGES(NS), .CODE_W(CW), .LAST_W(LW)) uut (
        .clk          (clk),
        .rst_n        (rst_n),
        .stage_code_i (stage_code_i),
        .last_code_i  (last_code_i),
        .stage_vld_i  (stage_vld_i),
        .out_vld_o    (out_vld_o),
        .out_word_o   (out_word_o)
    );

    always #4 clk = ~clk;

    int cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    int  tests = 0;
    int  fails = 0;
    bit  done  = 1'b0;

    typedef struct {
        logic [OW-1:0] word;
        int            due;
        bit            none;
        string         req;
    } exp_t;

    exp_t              sb[$];
    logic [NS*CW-1:0]  code_tab[int];
    logic [NS-1:0]     vm_tab[int];
    logic [OW-1:0]     last_word = '0;

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // Feeder: stage i of the sample started at cycle s is driven at cycle s+i (R4).
    always @(negedge clk) begin
        logic [(NS-1)*CW-1:0] sc;
        logic [LW-1:0]        lc;
        logic [NS-1:0]        vv;
        sc = '0; lc = '0; vv = '0;
        for (int i = 0; i < NS; i++) begin
            if (code_tab.exists(cyc - i)) begin
                if (i < NS - 1) sc[i*CW +: CW] = code_tab[cyc - i][i*CW +: CW];
                else            lc = code_tab[cyc - i][(NS-1)*CW +: LW];
                vv[i] = vm_tab[cyc - i][i];
            end
        end
        stage_code_i = sc;
        last_code_i  = lc;
        stage_vld_i  = vv;
    end

    // Monitor / scoreboard.
    always @(negedge clk) begin
        bit matched;
        exp_t it;
        matched = 1'b0;
        if (rst_n) begin
            if (sb.size() > 0 && sb[0].due == cyc) begin
                it = sb.pop_front();
                matched = 1'b1;
                if (it.none) begin
                    chk(!out_vld_o && out_word_o == last_word, it.req, "no strobe, word held",
                        64'({out_vld_o, out_word_o}), 64'({1'b0, last_word}));
                end else begin
                    chk(out_vld_o && out_word_o == it.word, it.req, "corrected word",
                        64'({out_vld_o, out_word_o}), 64'({1'b1, it.word}));
                end
            end
            if (out_vld_o && !matched) begin
                chk(1'b0, "R4", "unexpected strobe", 64'(out_word_o), 64'(0));
            end
            if (out_vld_o) last_word = out_word_o;
        end
    end

    // R1 with R7 limiting: weighted overlap sum of the stored codes.
    function automatic logic [OW-1:0] ref_sum(input logic [NS*CW-1:0] v);
        longint s;
        longint c;
        s = longint'(v[(NS-1)*CW +: LW]);
        for (int i = 0; i < NS - 1; i++) begin
            c = longint'(v[i*CW +: CW]);
            if (c > CMAX) c = CMAX;
            s += c << ((NS - 2 - i) * (CW - 1) + LW - 1);
        end
        return OW'(s);
    endfunction

    // R2/R3 stage model; pst selects a stage whose decision moves by pdir.
    function automatic logic [NS*CW-1:0] quantize(input longint x, input int pst, input int pdir);
        logic [NS*CW-1:0] v;
        longint r;
        longint rr;
        int c;
        int c2;
        v = '0;
        r = x;
        for (int i = 0; i < NS - 1; i++) begin
            c = 0;
            for (int t = 1; t <= CMAX; t++) begin
                if (r * (longint'(1) << (CW + 1)) >= longint'(2 * t + 1) * VREF) c = t;
            end
            if (i == pst) begin
                c2 = c + pdir;
                if (c2 >= 0 && c2 <= CMAX) begin
                    rr = r * (longint'(1) << (CW - 1)) - longint'(c2) * (VREF / 2);
                    if (rr >= 0 && rr < VREF) c = c2;
                end
            end
            r = r * (longint'(1) << (CW - 1)) - longint'(c) * (VREF / 2);
            v[i*CW +: CW] = CW'(c);
        end
        v[(NS-1)*CW +: LW] = LW'(r >>> (32 - LW));
        return v;
    endfunction

    task automatic send(input logic [NS*CW-1:0] codes, input logic [NS-1:0] vm,
                        input logic [OW-1:0] exp_word, input string req);
        exp_t it;
        int   st;
        @(negedge clk);
        st = cyc + 1;
        code_tab[st] = codes;
        vm_tab[st]   = vm;
        it.word = exp_word;
        it.due  = st + NS;
        it.none = (vm != '1);
        it.req  = req;
        sb.push_back(it);
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic summary();
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            tests++;
            fails++;
            $display("FAIL R4 watchdog: actual %0d cycles expected completion", cyc);
            summary();
            $finish;
        end
    end

    initial begin
        logic [NS*CW-1:0] v;
        longint x;
        repeat (3) @(negedge clk);
        chk(out_vld_o == 1'b0 && out_word_o == '0, "R9", "in reset",
            64'({out_vld_o, out_word_o}), 64'(0));
        rst_n = 1'b1;
        idle(2);
        chk(out_vld_o == 1'b0 && out_word_o == '0, "R9", "after reset",
            64'({out_vld_o, out_word_o}), 64'(0));

        // R1: zero, each weight alone, all legal maxima.
        send('0, '1, '0, "R1");
        for (int i = 0; i < NS - 1; i++) begin
            v = '0;
            v[i*CW +: CW] = CW'(1);
            send(v, '1, ref_sum(v), "R1");
        end
        v = '0;
        for (int i = 0; i < NS - 1; i++) v[i*CW +: CW] = CW'(CMAX);
        v[(NS-1)*CW +: LW] = '1;
        send(v, '1, '1, "R1");

        // R7: out-of-range code limited to the top legal level.
        v = '0;
        v[0 +: CW] = '1;
        send(v, '1, OW'(longint'(CMAX) << ((NS - 2) * (CW - 1) + LW - 1)), "R7");
        v = '0;
        for (int i = 0; i < NS - 1; i++) v[i*CW +: CW] = '1;
        send(v, '1, ref_sum(v), "R7");

        // R8: final code bits appear at the bottom of the word.
        for (int k = 0; k < 4; k++) begin
            v = quantize(longint'($urandom()), -1, 0);
            v[(NS-1)*CW +: LW] = LW'(k);
            send(v, '1, ref_sum(v), "R8");
        end
        idle(NS + 2);

        // R2 and R10: ideal codes, back to back.
        for (int n = 0; n < 40; n++) begin
            x = longint'($urandom());
            send(quantize(x, -1, 0), '1, OW'(x >>> (32 - OW)), "R2 R10");
        end
        send(quantize(64'sd0, -1, 0), '1, '0, "R2");
        send(quantize(VREF - 1, -1, 0), '1, '1, "R2");

        // R3: one decision moved by one step, with occasional gaps.
        for (int n = 0; n < 60; n++) begin
            x = longint'($urandom());
            send(quantize(x, $urandom_range(0, NS - 2), ($urandom_range(0, 1) == 0) ? -1 : 1),
                 '1, OW'(x >>> (32 - OW)), "R3");
            if (n % 7 == 3) idle(2);
        end

        // R5/R6: missing strobes of stage 0, a middle stage and the final stage.
        for (int k = 0; k < 3; k++) begin
            int miss;
            logic [NS-1:0] vm;
            miss = (k == 0) ? 0 : ((k == 1) ? NS / 2 : NS - 1);
            vm = '1;
            vm[miss] = 1'b0;
            x = longint'($urandom());
            send(quantize(x, -1, 0), '1, OW'(x >>> (32 - OW)), "R2");
            send(quantize(longint'($urandom()), -1, 0), vm, '0, "R5 R6");
            idle(1);
        end

        while (sb.size() > 0) @(negedge clk);
        idle(NS + 2);
        done = 1'b1;
        summary();
        $finish;
    end
endmodule